// File: doc/BRIEF.md
# T1 Digital-Multiplexer Channel-24 Overhead Inserter

This block sits in the transmit path of a T1 line interface and rewrites the overhead of the digital-multiplexer framing variant. The 193-bit frames arrive one bit at a time, each bit marked by a bit-enable. A free-running position counter tracks the frame bit and the frame number within the 12-frame multiframe. From that position the block overwrites the framing bit with the 12-frame alignment sequence. It can copy the framing bit into the bit that follows it as a diagnostic mimic. In every frame it also rewrites the last channel octet (channel 24) with a fixed data-service pattern, a data-link bit taken from an external HDLC source, and an active-low yellow-alarm bit.

Three single-cycle request inputs each invert exactly one overhead item: the next odd-frame framing bit, the next even-frame framing bit, or the six fixed bits of the next channel-24 octet. When framing is disabled, the incoming stream is forwarded untouched. Every output is registered, so each output bit appears one clock after the enabled input bit. The HDLC source gets a one-clock read strobe that tells it when to present its next bit.

Top module: `t1dm_ch24_ins`

## Requirements
- R1: After reset the first enabled bit is the framing bit of frame 1. The framing bit of frames 1..12 is 1,0,0,0,1,1,0,1,1,1,0,0. Each frame is 193 enabled bits, and the framing bit is bit position 0.
- R2: A one-cycle pulse on `inv_ft` inverts the next framing bit sent in an odd frame (1,3,..,11). A pulse on `inv_fs` inverts the next framing bit sent in an even frame (2,4,..,12). Each pulse affects one bit only, and a request stays pending while framing is disabled.
- R3: With `mimic_en` high, bit position 1 carries the framing bit just sent, including any inversion.
- R4: Channel 24 occupies positions 185..192, and position 185 is its first-sent bit (octet bit 8). Position 185 is 0, and positions 188..192 are 1,1,1,0,1.
- R5: A pulse on `inv_dds` inverts the six fixed bits of R4 in exactly one channel-24 octet: the next one that starts with framing enabled.
- R6: Position 186 carries `hdlc_bit` when `dl_byp` is 0 and carries `din` when `dl_byp` is 1.
- R7: `hdlc_rd` is high for one clock, in the same cycle that position 185 is output, only when `fdis` and `dl_byp` are both 0.
- R8: Position 187 is 0 when `yel_man` is 1, or when `yel_auto` and `red_alm` are both 1. Otherwise it is 1.
- R9: With `fdis` high, `dout` equals `din` at every position.
- R10: `dout_vld` follows `bit_en` one clock later. Each output bit appears one clock after its input bit. Positions that no other requirement names carry `din` unchanged.
- R11: While `rst` is high, `dout`, `dout_vld` and `hdlc_rd` are 0, and all pending inversion requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a valid serial bit on `din` |
| din | input | 1 | Serial input bit |
| fdis | input | 1 | Framing disable: pass the stream through |
| dl_byp | input | 1 | Data-link bypass: keep the payload bit at position 186 |
| yel_man | input | 1 | Send yellow alarm |
| yel_auto | input | 1 | Send yellow alarm automatically while `red_alm` is high |
| red_alm | input | 1 | Red alarm from the receive side |
| mimic_en | input | 1 | Copy the framing bit into position 1 |
| inv_ft | input | 1 | Request: invert the next odd-frame framing bit |
| inv_fs | input | 1 | Request: invert the next even-frame framing bit |
| inv_dds | input | 1 | Request: invert the fixed bits of the next channel-24 octet |
| hdlc_bit | input | 1 | Data-link bit from the HDLC source |
| dout | output | 1 | Serial output bit |
| dout_vld | output | 1 | Marks a valid bit on `dout` |
| hdlc_rd | output | 1 | Strobe telling the HDLC source to present its next bit |

## Verification
The bench walks multiframes with framing alternately enabled and disabled. It places inversion requests so that some wait across frames of the wrong parity, and some wait across disabled frames. A design that consumed a framing-bit request on the wrong parity, or during a disabled frame, would flip the wrong framing bit. A design that applied a data-service inversion to more than one octet would show wrong fixed bits in the following frame. The bench also checks the bypassed and non-bypassed data-link bit and the read strobe, so a strobe that is one bit late, or that fires in bypass, is caught. Finally, a reset in the middle of a frame must restart the count at frame 1, and a design that kept its count would send the wrong framing bit.

// File: rtl/t1dm_pkg.sv
`timescale 1ns/1ps
package t1dm_pkg;
  // Indices of the inversion-request flags
  localparam int REQ_FT  = 0;
  localparam int REQ_FS  = 1;
  localparam int REQ_DDS = 2;
  localparam int NREQ    = 3;

  // Channel-24 word layout, first-sent bit at the MSB
  localparam int     OCT_BITS = 8;
  localparam logic [OCT_BITS-1:0] DDS_VAL  = 8'b0001_1101;
  localparam logic [OCT_BITS-1:0] DDS_MASK = 8'b1001_1111;
  localparam int     D_OFS = 1;
  localparam int     Y_OFS = 2;

  // Framing sequence, bit i is the framing bit of frame i+1
  localparam logic [11:0] FAS_SEQ = 12'b0011_1011_0001;
endpackage

// File: rtl/t1dm_pos_cnt.sv
`timescale 1ns/1ps
module t1dm_pos_cnt #(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 12,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] pos,
  output logic [FW-1:0] frm
);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      frm <= '0;
    end else if (adv) begin
      if (pos == POS_LAST) begin
        pos <= '0;
        frm <= (frm == FRM_LAST) ? '0 : frm + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/t1dm_req_flag.sv
`timescale 1ns/1ps
module t1dm_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend
);
  // A new request wins over a take in the same cycle
  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (req)  pend <= 1'b1;
    else if (take) pend <= 1'b0;
  end
endmodule

// File: rtl/t1dm_ovh_sel.sv
`timescale 1ns/1ps
module t1dm_ovh_sel
  import t1dm_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 12,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          din,
  input  logic [PW-1:0] pos,
  input  logic [FW-1:0] frm,
  input  logic          fdis,
  input  logic          dl_byp,
  input  logic          yel_on,
  input  logic          mimic_en,
  input  logic          ft_pend,
  input  logic          fs_pend,
  input  logic          dds_pend,
  input  logic          dds_act,
  input  logic          fbit_q,
  input  logic          hdlc_bit,
  output logic          nxt,
  output logic          f_val,
  output logic          odd_frame
);
  localparam logic [PW-1:0] C24 = PW'(FRAME_BITS - OCT_BITS);

  logic [OCT_BITS-1:0] c24_hit;
  logic                fixed_bit;
  logic                fixed_inv;

  // Frame index 0 is frame 1, so even indices are odd frames
  assign odd_frame = ~frm[0];
  assign f_val     = FAS_SEQ[frm] ^ (odd_frame ? ft_pend : fs_pend);
  // First fixed bit uses the pending request, the rest the captured one
  assign fixed_inv = (pos == C24) ? dds_pend : dds_act;

  for (genvar k = 0; k < OCT_BITS; k++) begin : g_hit
    assign c24_hit[k] = (pos == C24 + PW'(k));
  end

  always_comb begin
    fixed_bit = 1'b0;
    for (int k = 0; k < OCT_BITS; k++)
      if (c24_hit[k]) fixed_bit = DDS_VAL[OCT_BITS-1-k];
  end

  always_comb begin
    nxt = din;
    if (!fdis) begin
      if (pos == '0)
        nxt = f_val;
      else if (pos == PW'(1) && mimic_en)
        nxt = fbit_q;
      else if (c24_hit[D_OFS])
        nxt = dl_byp ? din : hdlc_bit;
      else if (c24_hit[Y_OFS])
        nxt = ~yel_on;
      else if (|(c24_hit & {<<{DDS_MASK}}))
        nxt = fixed_bit ^ fixed_inv;
    end
  end
endmodule

// File: rtl/t1dm_ch24_ins.sv
`timescale 1ns/1ps
module t1dm_ch24_ins
  import t1dm_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 12,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(FRAMES)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic din,
  input  logic fdis,
  input  logic dl_byp,
  input  logic yel_man,
  input  logic yel_auto,
  input  logic red_alm,
  input  logic mimic_en,
  input  logic inv_ft,
  input  logic inv_fs,
  input  logic inv_dds,
  input  logic hdlc_bit,
  output logic dout,
  output logic dout_vld,
  output logic hdlc_rd
);
  localparam logic [PW-1:0] C24 = PW'(FRAME_BITS - OCT_BITS);

  logic [PW-1:0]   pos;
  logic [FW-1:0]   frm;
  logic [NREQ-1:0] req, take, pend;
  logic            nxt, f_val, odd_frame, yel_on;
  logic            fbit_q, dds_act;
  logic            at_f, at_c24;

  assign yel_on = yel_man | (yel_auto & red_alm);
  assign at_f   = bit_en & ~fdis & (pos == '0);
  assign at_c24 = bit_en & ~fdis & (pos == C24);

  t1dm_pos_cnt #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) u_cnt (
    .clk(clk), .rst(rst), .adv(bit_en), .pos(pos), .frm(frm)
  );

  assign req[REQ_FT]   = inv_ft;
  assign req[REQ_FS]   = inv_fs;
  assign req[REQ_DDS]  = inv_dds;
  assign take[REQ_FT]  = at_f & odd_frame;
  assign take[REQ_FS]  = at_f & ~odd_frame;
  assign take[REQ_DDS] = at_c24;

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    t1dm_req_flag u_flag (
      .clk(clk), .rst(rst), .req(req[i]), .take(take[i]), .pend(pend[i])
    );
  end

  t1dm_ovh_sel #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) u_sel (
    .din(din), .pos(pos), .frm(frm), .fdis(fdis), .dl_byp(dl_byp),
    .yel_on(yel_on), .mimic_en(mimic_en),
    .ft_pend(pend[REQ_FT]), .fs_pend(pend[REQ_FS]),
    .dds_pend(pend[REQ_DDS]), .dds_act(dds_act), .fbit_q(fbit_q),
    .hdlc_bit(hdlc_bit), .nxt(nxt), .f_val(f_val), .odd_frame(odd_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fbit_q  <= 1'b0;
      dds_act <= 1'b0;
    end else begin
      if (at_f)   fbit_q  <= f_val;
      if (at_c24) dds_act <= pend[REQ_DDS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= 1'b0;
      dout_vld <= 1'b0;
      hdlc_rd  <= 1'b0;
    end else begin
      dout_vld <= bit_en;
      hdlc_rd  <= at_c24 & ~dl_byp;
      if (bit_en) dout <= nxt;
    end
  end
endmodule

// File: rtl/t1dm_ch24_ins_chk.sv
`timescale 1ns/1ps
module t1dm_ch24_ins_chk #(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 12,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          din,
  input logic          fdis,
  input logic          dl_byp,
  input logic          yel_man,
  input logic          yel_auto,
  input logic          red_alm,
  input logic          hdlc_bit,
  input logic          dout,
  input logic          dout_vld,
  input logic          hdlc_rd,
  input logic [PW-1:0] pos,
  input logic [FW-1:0] frm
);
  localparam logic [PW-1:0] C24 = PW'(FRAME_BITS - 8);

  a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
    (bit_en && fdis) |=> (dout == $past(din)));

  a_r10_vld: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout_vld == $past(bit_en)));

  a_r7_rd_cond: assert property (@(posedge clk) disable iff (rst)
    hdlc_rd |-> ($past(bit_en) && !$past(fdis) && !$past(dl_byp)));

  a_r7_rd_single: assert property (@(posedge clk) disable iff (rst)
    hdlc_rd |=> !hdlc_rd);

  a_r6_dlink: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !fdis && pos == C24 + PW'(1))
      |=> (dout == ($past(dl_byp) ? $past(din) : $past(hdlc_bit))));

  a_r8_yellow: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !fdis && pos == C24 + PW'(2))
      |=> (dout == !($past(yel_man) || ($past(yel_auto) && $past(red_alm)))));

  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    (pos < PW'(FRAME_BITS)) && (frm < FW'(FRAMES)));
endmodule

bind t1dm_ch24_ins t1dm_ch24_ins_chk #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .fdis(fdis),
  .dl_byp(dl_byp), .yel_man(yel_man), .yel_auto(yel_auto),
  .red_alm(red_alm), .hdlc_bit(hdlc_bit), .dout(dout),
  .dout_vld(dout_vld), .hdlc_rd(hdlc_rd), .pos(pos), .frm(frm)
);

// File: tb/test_t1dm_ch24_ins.sv
`timescale 1ns/1ps
module test_t1dm_ch24_ins;
  localparam int NB = 193;
  localparam int NF = 12;
  localparam logic [11:0] FSEQ = 12'b0011_1011_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 0, din = 0, fdis = 0, dl_byp = 0, yel_man = 0, yel_auto = 0;
  logic red_alm = 0, mimic_en = 0, inv_ft = 0, inv_fs = 0, inv_dds = 0, hdlc_bit = 0;
  logic dout, dout_vld, hdlc_rd;

  always #4 clk = ~clk;

  t1dm_ch24_ins i_t1dm_ch24_ins (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .fdis(fdis),
    .dl_byp(dl_byp), .yel_man(yel_man), .yel_auto(yel_auto),
    .red_alm(red_alm), .mimic_en(mimic_en), .inv_ft(inv_ft),
    .inv_fs(inv_fs), .inv_dds(inv_dds), .hdlc_bit(hdlc_bit),
    .dout(dout), .dout_vld(dout_vld), .hdlc_rd(hdlc_rd)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  // {fdis,byp,ymn,yau,red,mim,pft,pfs,pdds,hd,dsel[1:0]}
  localparam logic [11:0] VEC [16] = '{
    12'b0000_0000_0100, 12'b0000_0010_0001, 12'b0000_0101_0010,
    12'b0010_0100_1000, 12'b0101_0000_0001, 12'b0101_1000_0010,
    12'b1000_0110_0010, 12'b1000_0000_1001, 12'b0000_0000_0100,
    12'b0000_0101_1001, 12'b0110_0000_0010, 12'b0000_0000_0101,
    12'b0001_1111_1000, 12'b0000_0000_0010, 12'b1000_0000_0000,
    12'b0000_0100_0101
  };

  // bench model state
  bit m_ft, m_fs, m_dds, m_act, m_lastf;

  task automatic chk(input bit act, input bit exp, input string req, input int p, input int f);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s frame %0d pos %0d: got %0b expected %0b", req, f + 1, p, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ft = 0; m_fs = 0; m_dds = 0; m_act = 0; m_lastf = 0;
  endtask

  // Run one frame with configuration v; f = frame index 0..11
  task automatic run_frame(input logic [11:0] v, input int f);
    bit vfd, vby, vym, vya, vrd, vmi, vpt, vps, vpd, vhd;
    bit [1:0] vds;
    {vfd, vby, vym, vya, vrd, vmi, vpt, vps, vpd, vhd, vds} = v;
    @(negedge clk);
    bit_en = 0; fdis = vfd; dl_byp = vby; yel_man = vym; yel_auto = vya;
    red_alm = vrd; mimic_en = vmi; inv_ft = vpt; inv_fs = vps; inv_dds = vpd;
    hdlc_bit = vhd;
    @(posedge clk);
    @(negedge clk);
    inv_ft = 0; inv_fs = 0; inv_dds = 0;
    m_ft |= vpt; m_fs |= vps; m_dds |= vpd;
    chk(dout_vld, 1'b0, "R10 vld low in gap", -1, f);
    for (int p = 0; p < NB; p++) begin
      bit d, e;
      string r;
      d = (vds == 2'd0) ? 1'b0 : (vds == 2'd1) ? 1'b1 : p[0];
      e = d; r = "R10 payload";
      if (vfd) begin
        r = "R9 passthru";
      end else if (p == 0) begin
        if (f % 2 == 0) begin e = FSEQ[f] ^ m_ft; m_ft = 0; end
        else            begin e = FSEQ[f] ^ m_fs; m_fs = 0; end
        m_lastf = e; r = "R1 R2 fbit";
      end else if (p == 1 && vmi) begin
        e = m_lastf; r = "R3 mimic";
      end else if (p >= 185) begin
        int k;
        bit [7:0] fx;
        fx = 8'b0001_1101;
        k = p - 185;
        if (k == 0) begin m_act = m_dds; m_dds = 0; end
        if (k == 1)      begin e = vby ? d : vhd; r = "R6 dlink"; end
        else if (k == 2) begin e = !(vym || (vya && vrd)); r = "R8 yellow"; end
        else             begin e = fx[7 - k] ^ m_act; r = "R4 R5 dds"; end
      end
      din = d; bit_en = 1;
      @(posedge clk);
      @(negedge clk);
      chk(dout, e, r, p, f);
      chk(dout_vld, 1'b1, "R10 vld", p, f);
      if (p == 185) chk(hdlc_rd, !vfd && !vby, "R7 strobe", p, f);
      if (p == 186) chk(hdlc_rd, 1'b0, "R7 strobe end", p, f);
    end
    bit_en = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout, 1'b0, "R11 reset dout", -1, 0);
    chk(dout_vld, 1'b0, "R11 reset vld", -1, 0);
    chk(hdlc_rd, 1'b0, "R11 reset rd", -1, 0);
    rst = 0;

    for (int i = 0; i < 16; i++) run_frame(VEC[i], i % NF);

    // Mid-frame reset: pending requests dropped, count restarts at frame 1
    @(negedge clk);
    inv_ft = 1; fdis = 0;
    @(negedge clk);
    inv_ft = 0; bit_en = 1; din = 0;
    repeat (50) @(negedge clk);
    bit_en = 0; rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk(dout_vld, 1'b0, "R11 mid reset vld", -1, 0);
    chk(dout, 1'b0, "R11 mid reset dout", -1, 0);
    rst = 0;
    model_reset();
    run_frame(12'b0000_0000_0000, 0);
    run_frame(12'b0000_0000_0001, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule